// File: doc/BRIEF.md
# DRAM power-up and self-refresh strobe sequencer

This block owns the row and column strobes of an asynchronous DRAM during two phases in which no normal access may run. The first is power-up. After reset the strobes stay idle for a start-up pause. A fixed number of warm-up refresh cycles then follows. The memory is declared ready only after the last of those cycles has finished its precharge. A parameter picks the kind of warm-up cycle: either a row-strobe-only refresh, or a refresh in which the column strobe falls before the row strobe.

The second phase is self-refresh. A request taken while the memory is ready lowers the column strobe first. The row strobe follows after a programmable lead. Both strobes then stay low for at least the minimum self-refresh time. An exit request may arrive at any time during entry or hold. It is remembered and served as soon as the minimum time has elapsed, and the block acknowledges it with a one-cycle pulse. Both strobes rise on the same clock edge. The block then holds them high for the exit precharge, whose length depends on the speed grade, and only after that does it report ready again.

Every timing is given in nanoseconds together with the clock period. Each one is turned into a whole number of clock cycles, rounded up.

Top module: `dram_pwr_seq`

## Requirements
- R1: Each timing becomes ceil(ns * 1000 / CLK_PERIOD_PS) cycles, with a minimum of 1. This applies to PAUSE_NS, WU_RAS_NS, WU_PRE_NS and SREF_MIN_NS. The exit precharge is 90 ns when SLOW_GRADE=0 and 110 ns when SLOW_GRADE=1.
- R2: During reset, and for exactly PAUSE_CYC cycles after the first rising edge at which rst is low, the outputs hold their idle values: ras_n=1, cas_n=1, ready=0, busy=0.
- R3: After the pause the block issues exactly WARMUP_COUNT warm-up cycles. In each one ras_n is low for WU_RAS_CYC cycles and high for WU_PRE_CYC cycles. ready rises right after the last precharge, PAUSE_CYC + WARMUP_COUNT*(L + WU_RAS_CYC + WU_PRE_CYC) cycles after the pause starts, where L=1 when WARMUP_CBR=1 and L=0 otherwise.
- R4: When WARMUP_CBR=1, cas_n in every warm-up cycle falls one cycle before ras_n and rises together with it. When WARMUP_CBR=0, cas_n stays high for the whole warm-up.
- R5: When sref_enter is sampled high while ready=1, the next cycle shows ready=0, busy=1, cas_n=0 and ras_n=1. This state lasts CAS_LEAD_CYC cycles, and then ras_n falls.
- R6: Let k be the rising edge, counted from the edge at which ras_n falls (that edge is 0), at which sref_exit is sampled. A request sampled during the column lead counts as k=0. ras_n then stays low for max(SREF_CYC, k) cycles. An early request is remembered.
- R7: At self-refresh exit, ras_n and cas_n rise on the same edge. exit_ack is high for exactly one cycle per exit, and that cycle is the first cycle of precharge.
- R8: After exit, ras_n and cas_n stay high with busy=1 for exactly SRPRE_CYC cycles. Then ready=1 and busy=0, and ready and busy are never high together.
- R9: An sref_exit sampled while ready=1 has no effect. busy stays low, and it is not remembered for a later self-refresh.
- R10: sref_enter has no effect during pause, during warm-up and during self-refresh. The warm-up timing and the self-refresh timing are unchanged by it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sref_enter | input | 1 | Self-refresh entry request, sampled while ready |
| sref_exit | input | 1 | Self-refresh exit request, remembered during entry and hold |
| ras_n | output | 1 | Row strobe, active low, registered |
| cas_n | output | 1 | Column strobe, active low, registered |
| ready | output | 1 | Memory may accept normal cycles |
| busy | output | 1 | Self-refresh entry, hold or exit precharge in progress |
| exit_ack | output | 1 | One-cycle pulse when an exit request is served |

## Verification
An exit request and the expiry of the minimum row-strobe-low window can land on the same clock edge. That edge must both end the hold and serve the request, without passing through the waiting state. The bench sweeps the request edge k across the whole window: from the column lead, through every hold cycle including k=SREF_CYC, to a few cycles past it. For each k it expects a low time of max(SREF_CYC, k), one acknowledge and the grade-dependent precharge. On odd sweeps a second entry request is placed inside the hold, to show that it leaves the timing untouched.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef enum logic [3:0] {
        ST_PAUSE,
        ST_WU_LEAD,
        ST_WU_ACT,
        ST_WU_PRE,
        ST_READY,
        ST_SR_LEAD,
        ST_SR_HOLD,
        ST_SR_WAIT,
        ST_SR_PRE
    } seq_state_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic ready;
        logic busy;
    } strobe_t;

    localparam int PRE_NS_FAST = 90;
    localparam int PRE_NS_SLOW = 110;

    // nanoseconds to clock cycles, rounded up, never below one
    function automatic int ns_to_cycles(input int ns, input int period_ps);
        int c;
        c = (ns * 1000 + period_ps - 1) / period_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // strobe levels seen while the sequencer sits in a given state
    function automatic strobe_t decode(input seq_state_e s, input logic cbr);
        strobe_t o;
        o = '{ras_n: 1'b1, cas_n: 1'b1, ready: 1'b0, busy: 1'b0};
        unique case (s)
            ST_WU_LEAD: o.cas_n = 1'b0;
            ST_WU_ACT: begin
                o.ras_n = 1'b0;
                o.cas_n = ~cbr;
            end
            ST_READY:   o.ready = 1'b1;
            ST_SR_LEAD: begin
                o.cas_n = 1'b0;
                o.busy  = 1'b1;
            end
            ST_SR_HOLD, ST_SR_WAIT: begin
                o.ras_n = 1'b0;
                o.cas_n = 1'b0;
                o.busy  = 1'b1;
            end
            ST_SR_PRE:  o.busy = 1'b1;
            default: ;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/dram_seq_timer.sv
module dram_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (cnt != TOP) cnt <= cnt + 1'b1;
    end

    // the saturating counter never wraps back to zero on its own
    a_r1_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (!clr && $past(!rst) && $past(cnt) != TOP) |-> cnt == $past(cnt) + 1'b1 || $past(clr) || $past(rst));
endmodule

// File: rtl/dram_seq_exit_latch.sv
module dram_seq_exit_latch (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic req,
    input  logic take,
    output logic pending
);
    logic q;

    assign pending = q | (arm & req);

    always_ff @(posedge clk) begin
        if (rst)              q <= 1'b0;
        else if (take)        q <= 1'b0;
        else if (arm && req)  q <= 1'b1;
    end

    // R6: a remembered exit request is kept until it is served
    a_r6_hold_pending: assert property (@(posedge clk) disable iff (rst)
        (q && !take) |=> q);
    // R9: nothing is remembered while the latch is not armed
    a_r9_no_capture: assert property (@(posedge clk) disable iff (rst)
        (!q && !arm) |=> !q);
endmodule

// File: rtl/dram_seq_warmup_ctr.sv
module dram_seq_warmup_ctr #(
    parameter int COUNT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output logic last
);
    localparam int CW = $clog2(COUNT + 1);
    localparam logic [CW-1:0] LAST_V = CW'(COUNT - 1);

    logic [CW-1:0] done_q;

    assign last = (done_q == LAST_V);

    always_ff @(posedge clk) begin
        if (rst)               done_q <= '0;
        else if (step && !last) done_q <= done_q + 1'b1;
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        step |=> done_q <= LAST_V);
endmodule

// File: rtl/dram_pwr_seq.sv
module dram_pwr_seq
    import dram_seq_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 10000,
    parameter int PAUSE_NS      = 200000,
    parameter int WARMUP_COUNT  = 8,
    parameter bit WARMUP_CBR    = 1'b1,
    parameter int WU_RAS_NS     = 60,
    parameter int WU_PRE_NS     = 40,
    parameter int SREF_MIN_NS   = 100000,
    parameter bit SLOW_GRADE    = 1'b0,
    parameter int CAS_LEAD_CYC  = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic sref_enter,
    input  logic sref_exit,
    output logic ras_n,
    output logic cas_n,
    output logic ready,
    output logic busy,
    output logic exit_ack
);
    localparam int PAUSE_CYC  = ns_to_cycles(PAUSE_NS, CLK_PERIOD_PS);
    localparam int WU_RAS_CYC = ns_to_cycles(WU_RAS_NS, CLK_PERIOD_PS);
    localparam int WU_PRE_CYC = ns_to_cycles(WU_PRE_NS, CLK_PERIOD_PS);
    localparam int SREF_CYC   = ns_to_cycles(SREF_MIN_NS, CLK_PERIOD_PS);
    localparam int SRPRE_CYC  = ns_to_cycles(SLOW_GRADE ? PRE_NS_SLOW : PRE_NS_FAST,
                                             CLK_PERIOD_PS);
    localparam int LEAD_CYC   = (CAS_LEAD_CYC < 1) ? 1 : CAS_LEAD_CYC;
    localparam int MAX_CYC    = max2(max2(PAUSE_CYC, SREF_CYC),
                                     max2(max2(WU_RAS_CYC, WU_PRE_CYC),
                                          max2(SRPRE_CYC, LEAD_CYC)));
    localparam int CW         = $clog2(MAX_CYC + 2);

    // pause counts from the first edge out of reset, hence no minus one
    localparam logic [CW-1:0] LIM_PAUSE = CW'(PAUSE_CYC);
    localparam logic [CW-1:0] LIM_ACT   = CW'(WU_RAS_CYC - 1);
    localparam logic [CW-1:0] LIM_PRE   = CW'(WU_PRE_CYC - 1);
    localparam logic [CW-1:0] LIM_LEAD  = CW'(LEAD_CYC - 1);
    localparam logic [CW-1:0] LIM_HOLD  = CW'(SREF_CYC - 1);
    localparam logic [CW-1:0] LIM_SRPRE = CW'(SRPRE_CYC - 1);

    seq_state_e    state, state_nxt, wu_first;
    logic [CW-1:0] cnt;
    logic          wu_last, wu_step;
    logic          exit_arm, exit_pend, exit_take;
    strobe_t       out_q;

    generate
        if (WARMUP_CBR) begin : g_wu_cbr
            assign wu_first = ST_WU_LEAD;
        end else begin : g_wu_ras
            assign wu_first = ST_WU_ACT;
        end
    endgenerate

    dram_seq_timer #(.W(CW)) u_timer (
        .clk (clk),
        .rst (rst),
        .clr (state_nxt != state),
        .cnt (cnt)
    );

    dram_seq_warmup_ctr #(.COUNT(WARMUP_COUNT)) u_wu (
        .clk  (clk),
        .rst  (rst),
        .step (wu_step),
        .last (wu_last)
    );

    assign exit_arm = (state == ST_SR_LEAD) || (state == ST_SR_HOLD) ||
                      (state == ST_SR_WAIT);

    dram_seq_exit_latch u_exit (
        .clk     (clk),
        .rst     (rst),
        .arm     (exit_arm),
        .req     (sref_exit),
        .take    (exit_take),
        .pending (exit_pend)
    );

    always_comb begin
        state_nxt = state;
        wu_step   = 1'b0;
        unique case (state)
            ST_PAUSE:   if (cnt == LIM_PAUSE) state_nxt = wu_first;
            ST_WU_LEAD: state_nxt = ST_WU_ACT;
            ST_WU_ACT:  if (cnt == LIM_ACT) state_nxt = ST_WU_PRE;
            ST_WU_PRE: begin
                if (cnt == LIM_PRE) begin
                    wu_step   = 1'b1;
                    state_nxt = wu_last ? ST_READY : wu_first;
                end
            end
            ST_READY:   if (sref_enter) state_nxt = ST_SR_LEAD;
            ST_SR_LEAD: if (cnt == LIM_LEAD) state_nxt = ST_SR_HOLD;
            ST_SR_HOLD: begin
                if (cnt == LIM_HOLD) state_nxt = exit_pend ? ST_SR_PRE : ST_SR_WAIT;
            end
            ST_SR_WAIT: if (exit_pend) state_nxt = ST_SR_PRE;
            ST_SR_PRE:  if (cnt == LIM_SRPRE) state_nxt = ST_READY;
            default:    state_nxt = ST_PAUSE;
        endcase
    end

    assign exit_take = (state_nxt == ST_SR_PRE) && (state != ST_SR_PRE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_PAUSE;
            out_q    <= decode(ST_PAUSE, WARMUP_CBR);
            exit_ack <= 1'b0;
        end else begin
            state    <= state_nxt;
            out_q    <= decode(state_nxt, WARMUP_CBR);
            exit_ack <= exit_take;
        end
    end

    assign ras_n = out_q.ras_n;
    assign cas_n = out_q.cas_n;
    assign ready = out_q.ready;
    assign busy  = out_q.busy;

    // run-length trackers of the row strobe, used by the checks below
    localparam int RW = $clog2(max2(SREF_CYC, SRPRE_CYC) + 2);
    localparam logic [RW-1:0] RUN_TOP = '1;
    logic [RW-1:0] lo_run, hi_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_run <= '0;
            hi_run <= '0;
        end else begin
            lo_run <= ras_n ? '0 : ((lo_run == RUN_TOP) ? lo_run : lo_run + 1'b1);
            hi_run <= !ras_n ? '0 : ((hi_run == RUN_TOP) ? hi_run : hi_run + 1'b1);
        end
    end

    a_r5_cas_before_ras: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n) && busy) |-> (!cas_n && $past(!cas_n)));

    generate
        if (WARMUP_CBR) begin : g_chk_cbr
            a_r4_wu_cas_lead: assert property (@(posedge clk) disable iff (rst)
                ($fell(ras_n) && !busy) |-> $past(!cas_n));
        end else begin : g_chk_ras
            a_r4_wu_cas_idle: assert property (@(posedge clk) disable iff (rst)
                (!busy && !ready) |-> cas_n);
        end
    endgenerate

    a_r6_min_low: assert property (@(posedge clk) disable iff (rst)
        ($rose(ras_n) && busy) |-> (lo_run >= RW'(SREF_CYC)));

    a_r7_ack_at_rise: assert property (@(posedge clk) disable iff (rst)
        exit_ack |-> ($rose(ras_n) && $rose(cas_n)));

    a_r8_min_precharge: assert property (@(posedge clk) disable iff (rst)
        ($rose(ready) && $past(busy)) |-> (hi_run >= RW'(SRPRE_CYC)));

    a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ready && busy));

    a_r3_ready_after_last: assert property (@(posedge clk) disable iff (rst)
        ($rose(ready) && !$past(busy)) |-> $past(wu_last));
endmodule

// File: tb/dram_pwr_seq_test.sv
module dram_pwr_seq_test;
    localparam int TCK       = 10;
    localparam int PER_PS    = 10000;
    localparam int PAUSE_NS  = 305;
    localparam int WU_N      = 8;
    localparam int WU_RAS_NS = 45;
    localparam int WU_PRE_NS = 31;
    localparam int SREF_NS   = 120;
    localparam int LEAD      = 1;

    // R1: rounded-up cycle counts computed here from the nanosecond values
    localparam int P_CYC    = (PAUSE_NS * 1000 + PER_PS - 1) / PER_PS;
    localparam int R_CYC    = (WU_RAS_NS * 1000 + PER_PS - 1) / PER_PS;
    localparam int PR_CYC   = (WU_PRE_NS * 1000 + PER_PS - 1) / PER_PS;
    localparam int S_CYC    = (SREF_NS * 1000 + PER_PS - 1) / PER_PS;
    localparam int PRE_FAST = (90 * 1000 + PER_PS - 1) / PER_PS;
    localparam int PRE_SLOW = (110 * 1000 + PER_PS - 1) / PER_PS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sref_enter = 1'b0;
    logic sref_exit = 1'b0;
    logic [1:0] m_ras, m_cas, m_rdy, m_busy, m_ack;

    always #(TCK / 2) clk = ~clk;

    dram_pwr_seq #(
        .CLK_PERIOD_PS(PER_PS), .PAUSE_NS(PAUSE_NS), .WARMUP_COUNT(WU_N),
        .WARMUP_CBR(1'b1), .WU_RAS_NS(WU_RAS_NS), .WU_PRE_NS(WU_PRE_NS),
        .SREF_MIN_NS(SREF_NS), .SLOW_GRADE(1'b0), .CAS_LEAD_CYC(LEAD)
    ) uut (
        .clk(clk), .rst(rst), .sref_enter(sref_enter), .sref_exit(sref_exit),
        .ras_n(m_ras[0]), .cas_n(m_cas[0]), .ready(m_rdy[0]), .busy(m_busy[0]),
        .exit_ack(m_ack[0])
    );

    dram_pwr_seq #(
        .CLK_PERIOD_PS(PER_PS), .PAUSE_NS(PAUSE_NS), .WARMUP_COUNT(WU_N),
        .WARMUP_CBR(1'b0), .WU_RAS_NS(WU_RAS_NS), .WU_PRE_NS(WU_PRE_NS),
        .SREF_MIN_NS(SREF_NS), .SLOW_GRADE(1'b1), .CAS_LEAD_CYC(LEAD)
    ) uut_ro (
        .clk(clk), .rst(rst), .sref_enter(sref_enter), .sref_exit(sref_exit),
        .ras_n(m_ras[1]), .cas_n(m_cas[1]), .ready(m_rdy[1]), .busy(m_busy[1]),
        .exit_ack(m_ack[1])
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // cumulative monitors, sampled a quarter period after each rising edge
    int ncyc = 0;
    int n_low[2], n_cas_only[2], n_cas_low[2], n_pre[2], n_ack[2], n_ack_ok[2];
    int n_fall[2], n_skew[2], first_act[2], first_rdy[2];
    logic prev_ras[2];

    initial begin
        for (int i = 0; i < 2; i++) begin
            n_low[i] = 0; n_cas_only[i] = 0; n_cas_low[i] = 0; n_pre[i] = 0;
            n_ack[i] = 0; n_ack_ok[i] = 0; n_fall[i] = 0; n_skew[i] = 0;
            first_act[i] = 0; first_rdy[i] = 0; prev_ras[i] = 1'b1;
        end
    end

    always @(posedge clk) begin
        #(TCK / 4);
        if (!rst) begin
            ncyc++;
            for (int i = 0; i < 2; i++) begin
                if (!m_ras[i]) n_low[i]++;
                if (!m_cas[i] && m_ras[i]) n_cas_only[i]++;
                if (!m_cas[i]) n_cas_low[i]++;
                if (m_busy[i] && m_ras[i] && m_cas[i]) n_pre[i]++;
                if (m_busy[i] && !m_ras[i] && m_cas[i]) n_skew[i]++;
                if (m_ack[i]) n_ack[i]++;
                if (m_ack[i] && m_ras[i] && m_cas[i] && !prev_ras[i]) n_ack_ok[i]++;
                if (prev_ras[i] && !m_ras[i]) n_fall[i]++;
                if (first_act[i] == 0 && (!m_ras[i] || !m_cas[i])) first_act[i] = ncyc;
                if (first_rdy[i] == 0 && m_rdy[i]) first_rdy[i] = ncyc;
                prev_ras[i] = m_ras[i];
            end
        end
    end

    task automatic episode(input int d);
        int s_low[2], s_co[2], s_pre[2], s_ack[2], s_ok[2], s_skew[2];
        int m;
        int exp_low;
        m = LEAD + d;
        exp_low = (d > S_CYC) ? d : S_CYC;
        @(negedge clk);
        while (m_rdy != 2'b11 || m_busy != 2'b00) @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            s_low[i] = n_low[i]; s_co[i] = n_cas_only[i]; s_pre[i] = n_pre[i];
            s_ack[i] = n_ack[i]; s_ok[i] = n_ack_ok[i]; s_skew[i] = n_skew[i];
        end
        sref_enter = 1'b1;
        for (int k = 1; k <= m; k++) begin
            @(negedge clk);
            if (k == 1) begin
                for (int i = 0; i < 2; i++)
                    check(m_busy[i] && !m_rdy[i] && !m_cas[i] && m_ras[i],
                          $sformatf("R5 entry inst%0d d=%0d {busy,rdy,cas,ras}", i, d),
                          {m_busy[i], m_rdy[i], m_cas[i], m_ras[i]}, 4'b1001);
            end
            sref_enter = ((d % 2) == 1) && (k == 2);
            sref_exit  = (k == m);
        end
        @(negedge clk);
        sref_exit  = 1'b0;
        sref_enter = 1'b0;
        while (m_rdy != 2'b11) @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            check(n_low[i] - s_low[i] == exp_low,
                  $sformatf("R6 low width inst%0d d=%0d", i, d), n_low[i] - s_low[i], exp_low);
            check(n_cas_only[i] - s_co[i] == LEAD,
                  $sformatf("R5 cas lead inst%0d d=%0d", i, d), n_cas_only[i] - s_co[i], LEAD);
            check(n_pre[i] - s_pre[i] == ((i == 0) ? PRE_FAST : PRE_SLOW),
                  $sformatf("R8 precharge inst%0d d=%0d", i, d), n_pre[i] - s_pre[i],
                  (i == 0) ? PRE_FAST : PRE_SLOW);
            check(n_ack[i] - s_ack[i] == 1,
                  $sformatf("R7 ack count inst%0d d=%0d", i, d), n_ack[i] - s_ack[i], 1);
            check(n_ack_ok[i] - s_ok[i] == 1,
                  $sformatf("R7 ack at joint rise inst%0d d=%0d", i, d), n_ack_ok[i] - s_ok[i], 1);
            check(n_skew[i] - s_skew[i] == 0,
                  $sformatf("R10 R7 no ras-only low inst%0d d=%0d", i, d), n_skew[i] - s_skew[i], 0);
        end
    endtask

    initial begin
        #(TCK * 100000);
        n_err++;
        $display("FAIL watchdog expired act=%0d exp=%0d", ncyc, 0);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        for (int i = 0; i < 2; i++)
            check(m_ras[i] && m_cas[i] && !m_rdy[i] && !m_busy[i],
                  $sformatf("R2 reset idle inst%0d {ras,cas,rdy,busy}", i),
                  {m_ras[i], m_cas[i], m_rdy[i], m_busy[i]}, 4'b1100);
        rst = 1'b0;
        // R10: requests during the pause and during warm-up change nothing
        repeat (5) @(negedge clk);
        sref_enter = 1'b1;
        @(negedge clk);
        sref_enter = 1'b0;
        sref_exit  = 1'b1;
        @(negedge clk);
        sref_exit = 1'b0;
        repeat (50) @(negedge clk);
        sref_enter = 1'b1;
        @(negedge clk);
        sref_enter = 1'b0;
        while (m_rdy != 2'b11) @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            int lead_i;
            lead_i = (i == 0) ? 1 : 0;
            check(first_act[i] == P_CYC + 1,
                  $sformatf("R1 R2 pause length inst%0d", i), first_act[i] - 1, P_CYC);
            check(first_rdy[i] == P_CYC + WU_N * (lead_i + R_CYC + PR_CYC) + 1,
                  $sformatf("R3 R10 ready time inst%0d", i), first_rdy[i] - 1,
                  P_CYC + WU_N * (lead_i + R_CYC + PR_CYC));
            check(n_fall[i] == WU_N, $sformatf("R3 warm-up count inst%0d", i), n_fall[i], WU_N);
            check(n_low[i] == WU_N * R_CYC, $sformatf("R3 warm-up low total inst%0d", i),
                  n_low[i], WU_N * R_CYC);
            check(n_cas_only[i] == WU_N * lead_i, $sformatf("R4 cas lead total inst%0d", i),
                  n_cas_only[i], WU_N * lead_i);
            check(n_cas_low[i] == WU_N * lead_i * (1 + R_CYC),
                  $sformatf("R4 cas low total inst%0d", i), n_cas_low[i],
                  WU_N * lead_i * (1 + R_CYC));
            check(m_busy[i] == 1'b0, $sformatf("R10 not busy after warm-up inst%0d", i),
                  m_busy[i], 0);
        end
        // R9: exit while ready is ignored and not remembered
        @(negedge clk);
        sref_exit = 1'b1;
        @(negedge clk);
        sref_exit = 1'b0;
        for (int i = 0; i < 2; i++)
            check(!m_busy[i] && m_ras[i] && m_rdy[i],
                  $sformatf("R9 exit in ready inst%0d {busy,ras,rdy}", i),
                  {m_busy[i], m_ras[i], m_rdy[i]}, 3'b011);
        episode(S_CYC + 5);
        for (int d = 0; d <= S_CYC + 3; d++) episode(d);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule